// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block turns an asynchronous serial line into bytes. The line idles high. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit, so a frame is ten bit times long. A divider inside the block produces a sampling tick from the system clock. There are sixteen ticks in each bit period. The receiver looks at the line only on those ticks.

The falling edge that begins a start bit is the only point where the receiver realigns its bit timing. After that edge, every bit is decided by a majority of five consecutive tick samples centred on the middle of the bit. The start bit is judged the same way. If its vote comes out high, the edge is taken as a spike and the receiver returns to idle.

When a frame ends, the byte is presented with a one-cycle strobe. If the stop bit votes low, a framing-error flag is raised in the same cycle, and the receiver waits for the line to return high before it looks for a new start edge.

Top module: `uart_rx_vote`

## Requirements
- R1: After the synchronous reset is released, `valid_o` and `frame_err_o` are 0 and `data_o` is all zeros until the first frame has been received.
- R2: A sampling tick occurs once every `CLK_DIV` system clocks, and one bit period is 16 ticks (16*CLK_DIV clocks). Outputs change only in the cycle after a tick.
- R3: For a frame of start(0), d0..d7, stop(1), `data_o` equals the byte whose bit i is di, so the first data bit on the line lands in bit 0. `data_o` holds its value between strobes.
- R4: Each received frame gives exactly one `valid_o` pulse, and that pulse is one clock wide.
- R5: A low pulse on an idle line that has returned high before the start-bit vote produces no strobe, and a normal frame sent afterwards is received correctly.
- R6: Each bit value is the majority of the 5 tick samples at positions 6..10 of the bit, counted from the tick that first saw the line low (position 0). A spike lasting one tick inside a data bit does not change the received byte.
- R7: Frames whose bit period differs from 16*CLK_DIV clocks by plus or minus 3 percent are received correctly.
- R8: When the stop bit votes low, `frame_err_o` is 1 in the same cycle as `valid_o`, and `data_o` still carries the eight received data bits.
- R9: After a framing error, the receiver detects no start edge while the line stays low. It accepts a new frame only after the line has been seen high.
- R10: The line passes through a two-flop synchroniser. `valid_o` rises in the clock after the tick at position 10 of the stop bit, which is tick 154 counted from the detecting tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| data_o | output | DATA_W | Last received byte, LSB received first |
| valid_o | output | 1 | One-cycle strobe: a new byte is on `data_o` |
| frame_err_o | output | 1 | Stop bit voted low; pulses only with `valid_o` |

## Verification
The byte strobe and the framing-error flag can be raised in the same clock. That happens at the stop-bit decision of a frame whose stop bit is driven low. The bench sends such a frame with a known byte and holds the line low afterwards. It then expects one cycle in which the strobe is high, the error flag is high and the byte matches the one sent. No further strobe may appear until the line is released. A behavioural tick-level model tracks every clock, so the exact cycle of that coincidence is compared as well as its values.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_STOP   = 3'd3,
    ST_WAITHI = 3'd4
  } urx_state_e;
endpackage

// File: rtl/urx_prescale.sv
// Divides the system clock down to the oversampling tick.
module urx_prescale #(
  parameter int DIV = 326
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV < 2) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/urx_sync.sv
// Multi-flop synchroniser; resets to the idle (high) level.
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate
  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/urx_voter.sv
// Accumulates samples in a window centred on the bit middle and
// delivers the majority at the last tick of the window.
module urx_voter #(
  parameter int OVS    = 16,
  parameter int VOTE_N = 5,
  localparam int PW    = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [PW-1:0] pos,
  input  logic          bit_in,
  output logic          done_o,
  output logic          val_o
);
  localparam int HALF = VOTE_N / 2;
  localparam int CTR  = OVS / 2;
  localparam int CW   = $clog2(VOTE_N + 1);
  localparam logic [PW-1:0] WLO = PW'(CTR - HALF);
  localparam logic [PW-1:0] WHI = PW'(CTR + HALF);

  logic [CW-1:0] acc_q;
  logic          in_win;
  logic [CW:0]   sum_w;

  assign in_win = (pos >= WLO) && (pos <= WHI);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (tick && in_win) begin
      if (pos == WHI) acc_q <= '0;
      else            acc_q <= acc_q + CW'(bit_in);
    end
  end

  assign sum_w  = {1'b0, acc_q} + (CW+1)'(bit_in);
  assign done_o = tick && (pos == WHI);
  assign val_o  = (sum_w > (CW+1)'(HALF));
endmodule

// File: rtl/uart_rx_vote.sv
// Oversampling serial receiver: start-edge search, voted bit recovery,
// byte strobe and framing-error flag.
module uart_rx_vote #(
  parameter int CLK_DIV = 326,
  parameter int OVS     = 16,
  parameter int VOTE_N  = 5,
  parameter int DATA_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  import urx_pkg::*;

  localparam int PW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic              tick_w;
  logic              rx_s;
  logic              vote_done;
  logic              vote_val;
  urx_state_e        st_q;
  logic [PW-1:0]     pos_q;
  logic [PW-1:0]     pos_nx;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shr_q;

  urx_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk(clk_i), .rst(rst_i), .tick_o(tick_w)
  );

  urx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk_i), .rst(rst_i), .din(rx_i), .dout(rx_s)
  );

  urx_voter #(.OVS(OVS), .VOTE_N(VOTE_N)) u_vote (
    .clk(clk_i), .rst(rst_i), .clr(st_q == ST_IDLE), .tick(tick_w),
    .pos(pos_q), .bit_in(rx_s), .done_o(vote_done), .val_o(vote_val)
  );

  assign pos_nx = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q        <= ST_IDLE;
      pos_q       <= '0;
      bit_q       <= '0;
      shr_q       <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      if (tick_w) begin
        case (st_q)
          ST_IDLE: begin
            if (!rx_s) begin
              st_q  <= ST_START;
              pos_q <= PW'(1);
            end
          end
          ST_START: begin
            pos_q <= pos_nx;
            if (vote_done) begin
              if (vote_val) begin
                st_q  <= ST_IDLE;
                pos_q <= '0;
              end else begin
                st_q  <= ST_DATA;
                bit_q <= '0;
              end
            end
          end
          ST_DATA: begin
            pos_q <= pos_nx;
            if (vote_done) begin
              shr_q <= {vote_val, shr_q[DATA_W-1:1]};
              if (bit_q == BIT_LAST) st_q <= ST_STOP;
              else                   bit_q <= bit_q + 1'b1;
            end
          end
          ST_STOP: begin
            pos_q <= pos_nx;
            if (vote_done) begin
              data_o      <= shr_q;
              valid_o     <= 1'b1;
              frame_err_o <= !vote_val;
              st_q        <= vote_val ? ST_IDLE : ST_WAITHI;
              pos_q       <= '0;
            end
          end
          ST_WAITHI: begin
            if (rx_s) st_q <= ST_IDLE;
          end
          default: begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_rx_chk.sv
module urx_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              valid,
  input logic              ferr,
  input logic [DATA_W-1:0] data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && !ferr));
  // R2
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(tick));
  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R8
  err_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ferr |-> valid);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid && !$past(rst)) |-> $stable(data));
endmodule

bind uart_rx_vote urx_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk_i), .rst(rst_i), .tick(tick_w), .valid(valid_o),
  .ferr(frame_err_o), .data(data_o)
);

// File: tb/uart_rx_vote_test.sv
module uart_rx_vote_test;
  localparam int DIV = 10;
  localparam int NOM = 16 * DIV;
  localparam int WLO = 6;
  localparam int WHI = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, frame_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  uart_rx_vote #(.CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_i(rst), .rx_i(rx),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  // behavioural tick-level reference
  logic       m1, m2, mv, me, vv;
  logic [7:0] mby, mdata;
  logic       samp [16];
  int         pc, ms, mt, nb, vc;

  always @(posedge clk) begin
    if (rst) begin
      m1 <= 1; m2 <= 1; pc <= 0; ms <= 0; mt <= 0; nb <= 0;
      mby <= 0; mdata <= 0; mv <= 0; me <= 0;
    end else begin
      m1 <= rx; m2 <= m1;
      pc <= (pc == DIV-1) ? 0 : pc + 1;
      mv <= 0; me <= 0;
      if (pc == DIV-1) begin
        if (ms == 0) begin
          if (!m2) begin ms <= 1; mt <= 1; end
        end else if (ms == 4) begin
          if (m2) ms <= 0;
        end else begin
          samp[mt] = m2;
          mt <= (mt + 1) % 16;
          if (mt == WHI) begin
            vc = 0;
            for (int k = WLO; k <= WHI; k++) vc += int'(samp[k]);
            vv = (vc > 2);
            if (ms == 1) begin
              if (vv) begin ms <= 0; mt <= 0; end
              else begin ms <= 2; nb <= 0; end
            end else if (ms == 2) begin
              mby[nb] <= vv;
              if (nb == 7) ms <= 3; else nb <= nb + 1;
            end else begin
              mdata <= mby; mv <= 1; me <= !vv;
              ms <= vv ? 0 : 4; mt <= 0;
            end
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R10) and frame bookkeeping
  int    exp_d[$];
  int    exp_e[$];
  string exp_t[$];
  logic  prev_v = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check("R10 valid", valid_o, mv);
      check("R10 err", frame_err_o, me);
      check("R10 data", data_o, mdata);
      if (valid_o && prev_v) check("R4 width", 0, 1);
      if (valid_o) begin
        if (exp_d.size() == 0) check("R4/R5 unexpected strobe", 1, 0);
        else begin
          string t;
          int d, e;
          t = exp_t.pop_front(); d = exp_d.pop_front(); e = exp_e.pop_front();
          check({t, " data"}, data_o, d);
          check({t, " err"}, frame_err_o, e);
        end
      end
      prev_v <= valid_o;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rx = 1'b1; end
  endtask

  // spk_bit: frame bit index (1..8 data) receiving a one-tick spike at its centre
  task automatic send(input logic [7:0] d, input int bc, input logic stopv,
                      input int spk_bit, input logic spk_val,
                      input string tag, input int experr);
    exp_d.push_back(d); exp_e.push_back(experr); exp_t.push_back(tag);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stopv : d[i-1];
      for (int c = 0; c < bc; c++) begin
        @(negedge clk);
        if (i == spk_bit && c >= bc/2 - DIV/2 && c < bc/2 - DIV/2 + DIV) rx = spk_val;
        else rx = v;
      end
    end
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    wrap_up();
  end

  initial begin
    repeat (8) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 valid", valid_o, 0);
    check("R1 err", frame_err_o, 0);
    check("R1 data", data_o, 0);
    idle(2*NOM);
    // R2 R3: nominal rate, LSB first
    send(8'hA5, NOM, 1, -1, 0, "R3", 0); idle(2*NOM);
    send(8'h00, NOM, 1, -1, 0, "R2", 0); idle(2*NOM);
    send(8'hFF, NOM, 1, -1, 0, "R3", 0); idle(2*NOM);
    send(8'h3C, NOM, 1, -1, 0, "R2", 0); idle(2*NOM);
    // R7: +3% and -3% bit period
    send(8'h5A, 165, 1, -1, 0, "R7 slow", 0); idle(2*NOM);
    send(8'hC3, 165, 1, -1, 0, "R7 slow", 0); idle(2*NOM);
    send(8'h96, 155, 1, -1, 0, "R7 fast", 0); idle(2*NOM);
    send(8'h01, 155, 1, -1, 0, "R7 fast", 0); idle(2*NOM);
    // R5: three-tick low glitch, no strobe expected
    for (int i = 0; i < 3*DIV; i++) begin @(negedge clk); rx = 1'b0; end
    idle(2*NOM);
    check("R5 no strobe pending", exp_d.size(), 0);
    send(8'h77, NOM, 1, -1, 0, "R5 after glitch", 0); idle(2*NOM);
    // R6: one-tick spikes at bit centres
    send(8'h00, NOM, 1, 4, 1, "R6 high spike", 0); idle(2*NOM);
    send(8'hFF, NOM, 1, 6, 0, "R6 low spike", 0); idle(2*NOM);
    // R8 R9: low stop bit, line held low
    send(8'h4B, NOM, 0, -1, 0, "R8", 1);
    for (int i = 0; i < 3*NOM; i++) begin @(negedge clk); rx = 1'b0; end
    check("R9 no restart while low", exp_d.size(), 0);
    idle(2*NOM);
    send(8'h81, NOM, 1, -1, 0, "R9 after release", 0); idle(3*NOM);
    check("R4 all frames strobed once", exp_d.size(), 0);
    wrap_up();
  end
endmodule